// File: doc/BRIEF.md
# Sized Add/Subtract Unit with Condition Code Register

This block does the integer arithmetic of a small processor datapath and keeps the 8-bit condition code register that goes with it. One operation can be issued per clock. The operation is one of add, add with carry, subtract, subtract with borrow, compare or negate, and it works on an 8-, 16- or 32-bit operand chosen by a size input. The result appears combinationally on the result port. The half-carry, negative, zero, overflow and carry flags are written into the register on the next rising clock edge.

Software can load the whole register, read it at any time, and merge an immediate into it with AND, OR or XOR. An exception-entry strobe forces the interrupt mask bit to one. That bit is also driven out as a mask for an external interrupt controller, which gates every interrupt except the non-maskable one.

Top module: `sized_alu_cc`

## Requirements
- R1: While reset is high, the register is 8'h80 on the clock edge: I is one and every other bit is zero. `irq_mask` is then one.
- R2: `op_code` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 negate. `op_size` selects the width: 0 byte, 1 word, 2 or 3 long. `result` is the operation computed on the low bits of the operands at that width and zero-extended to 32 bits. Subtraction is `opnd_a - opnd_b`. Negate is `0 - opnd_a`. Add with carry adds the current C, and subtract with borrow also subtracts it. Codes 6 and 7 do nothing.
- R3: H is the carry (or, for a subtraction, the borrow) out of bit 3 for a byte, bit 11 for a word and bit 27 for a long.
- R4: N is the top bit of the result at the active width. Z is one exactly when that result is zero.
- R5: V is one on signed overflow. C is the carry out of the top bit for additions and the borrow for subtractions and negate.
- R6: `result_we` is high for a valid add, add with carry, subtract, subtract with borrow or negate. It is low for compare, for codes 6 and 7, and when `op_valid` is low. Compare still updates the flags exactly as subtract does.
- R7: Register layout, from bit 7 to bit 0, is I, UI, H, U, N, Z, V, C. An operation leaves I, UI and U unchanged. When no write, merge, operation or exception entry occurs, the register holds its value.
- R8: `ccr_wr_en` loads all eight bits from `ccr_wr_data`. It takes priority over a merge and over an operation in the same cycle.
- R9: `ccr_logic_en` merges `ccr_logic_imm` into the register. `ccr_logic_fn` 0 gives AND, 1 gives OR, 2 gives XOR, and 3 leaves the register unchanged. A merge takes priority over an operation.
- R10: `exc_entry` sets I to one. The other bits follow the write, merge or operation of that cycle. I is one even if a write or merge in the same cycle would clear it.
- R11: `irq_mask` equals bit 7 (I) of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand width select |
| opnd_a | input | 32 | Destination operand (minuend) |
| opnd_b | input | 32 | Source operand (subtrahend) |
| result | output | 32 | Zero-extended result |
| result_we | output | 1 | Result should be written back |
| ccr_wr_en | input | 1 | Load the register |
| ccr_wr_data | input | 8 | Value to load |
| ccr_logic_en | input | 1 | Merge an immediate into the register |
| ccr_logic_fn | input | 2 | Merge function |
| ccr_logic_imm | input | 8 | Merge immediate |
| exc_entry | input | 1 | Exception handling begins |
| ccr_q | output | 8 | Current register value |
| irq_mask | output | 1 | Mask for maskable interrupts |

## Verification
The bench goes after the half-carry tap at each width. A word add of 0x000F+1 must leave H clear, and a design that tapped bit 3 at every size would set it. Operands with upper bits set at byte and word width catch a unit that lets those bits reach the result, Z or C. Negate of 0x80 and of zero, compare, and the borrow-in of subtract with borrow probe the inverted-carry convention, where a polarity slip flips C and H. Same-cycle collisions of exception entry, load, merge and operation expose a wrong priority, most visibly an I bit cleared by a write during exception entry.

// File: rtl/sized_alu_pkg.sv
package sized_alu_pkg;

    localparam int DW = 32;
    localparam int CW = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_NONE = 2'd3
    } logic_fn_e;

    // bit order is behaviour: software sees this exact byte
    typedef struct packed {
        logic i;
        logic ui;
        logic h;
        logic u;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic [DW-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: width_mask = DW'(32'h0000_00FF);
            SZ_WORD: width_mask = DW'(32'h0000_FFFF);
            default: width_mask = {DW{1'b1}};
        endcase
    endfunction

    function automatic int top_bit(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: top_bit = 7;
            SZ_WORD: top_bit = 15;
            default: top_bit = DW - 1;
        endcase
    endfunction

    // half-carry is taken four bits below the top
    function automatic int half_bit(input logic [1:0] sz);
        half_bit = top_bit(sz) - 4;
    endfunction

    function automatic logic [CW-1:0] merge_imm(input logic [CW-1:0] cur,
                                               input logic [1:0] fn,
                                               input logic [CW-1:0] imm);
        case (fn)
            LG_AND:  merge_imm = cur & imm;
            LG_OR:   merge_imm = cur | imm;
            LG_XOR:  merge_imm = cur ^ imm;
            default: merge_imm = cur;
        endcase
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import sized_alu_pkg::*;
(
    input  logic [2:0]    op,
    input  logic [1:0]    sz,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          known,
    output flags_t        fl
);

    logic [DW-1:0] mask;
    logic [DW-1:0] x_op;
    logic [DW-1:0] y_op;
    logic [DW-1:0] aa;
    logic [DW-1:0] bb;
    logic          inv;
    logic          cin;
    logic [DW:0]   sum;
    logic [DW:0]   cvec;
    int            msb;
    int            hb;

    always_comb begin
        known = 1'b1;
        inv   = 1'b0;
        cin   = 1'b0;
        x_op  = a;
        y_op  = b;
        case (op)
            OP_ADD:  ;
            OP_ADDC: cin = c_in;
            OP_SUB,
            OP_CMP:  begin inv = 1'b1; cin = 1'b1; end
            OP_SUBB: begin inv = 1'b1; cin = ~c_in; end
            OP_NEG:  begin x_op = '0; y_op = a; inv = 1'b1; cin = 1'b1; end
            default: begin known = 1'b0; y_op = '0; end
        endcase

        mask = width_mask(sz);
        msb  = top_bit(sz);
        hb   = half_bit(sz);
        aa   = x_op & mask;
        bb   = (inv ? ~y_op : y_op) & mask;
        sum  = {1'b0, aa} + {1'b0, bb} + {{DW{1'b0}}, cin};
        // carry into each bit position, recovered from the sum
        cvec = sum ^ {1'b0, aa} ^ {1'b0, bb};
        res  = sum[DW-1:0] & mask;

        fl.h = cvec[hb + 1] ^ inv;
        fl.c = cvec[msb + 1] ^ inv;
        fl.v = cvec[msb + 1] ^ cvec[msb];
        fl.n = sum[msb];
        fl.z = (res == '0);
    end

endmodule

// File: rtl/ccr_file.sv
module ccr_file
    import sized_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          alu_upd,
    input  flags_t        alu_fl,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          lg_en,
    input  logic [1:0]    lg_fn,
    input  logic [CW-1:0] lg_imm,
    input  logic          exc,
    output ccr_t          q
);

    ccr_t nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt = ccr_t'(wr_data);
        end else if (lg_en) begin
            nxt = ccr_t'(merge_imm(q, lg_fn, lg_imm));
        end else if (alu_upd) begin
            nxt.h = alu_fl.h;
            nxt.n = alu_fl.n;
            nxt.z = alu_fl.z;
            nxt.v = alu_fl.v;
            nxt.c = alu_fl.c;
        end
        if (exc) begin
            nxt.i = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ccr_t'(8'h80);
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/sized_alu_cc.sv
module sized_alu_cc
    import sized_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [1:0]    op_size,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] result,
    output logic          result_we,
    input  logic          ccr_wr_en,
    input  logic [CW-1:0] ccr_wr_data,
    input  logic          ccr_logic_en,
    input  logic [1:0]    ccr_logic_fn,
    input  logic [CW-1:0] ccr_logic_imm,
    input  logic          exc_entry,
    output logic [CW-1:0] ccr_q,
    output logic          irq_mask
);

    flags_t fl;
    logic   known;
    ccr_t   cc;

    alu_addsub u_arith (
        .op    (op_code),
        .sz    (op_size),
        .a     (opnd_a),
        .b     (opnd_b),
        .c_in  (cc.c),
        .res   (result),
        .known (known),
        .fl    (fl)
    );

    ccr_file u_ccr (
        .clk     (clk),
        .rst     (rst),
        .alu_upd (op_valid & known),
        .alu_fl  (fl),
        .wr_en   (ccr_wr_en),
        .wr_data (ccr_wr_data),
        .lg_en   (ccr_logic_en),
        .lg_fn   (ccr_logic_fn),
        .lg_imm  (ccr_logic_imm),
        .exc     (exc_entry),
        .q       (cc)
    );

    assign result_we = op_valid & known & (op_code != OP_CMP);
    assign ccr_q     = cc;
    assign irq_mask  = cc.i;

endmodule

// File: rtl/sized_alu_cc_chk.sv
module sized_alu_cc_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic [31:0] result,
    input logic        result_we,
    input logic        ccr_wr_en,
    input logic [7:0]  ccr_wr_data,
    input logic        ccr_logic_en,
    input logic        exc_entry,
    input logic [7:0]  ccr_q,
    input logic        irq_mask
);

    logic quiet;
    assign quiet = !ccr_wr_en && !ccr_logic_en && !exc_entry;

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ccr_q == 8'h80) && irq_mask);

    p_exc_sets_mask_r10: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> ccr_q[7] && irq_mask);

    p_load_low_bits_r8: assert property (@(posedge clk) disable iff (rst)
        ccr_wr_en |=> ccr_q[6:0] == $past(ccr_wr_data[6:0]));

    p_keep_user_bits_r7: assert property (@(posedge clk) disable iff (rst)
        op_valid && quiet |=> {ccr_q[7:6], ccr_q[4]} == $past({ccr_q[7:6], ccr_q[4]}));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !op_valid && quiet |=> $stable(ccr_q));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code <= 3'd5) && quiet |=> ccr_q[2] == ($past(result) == 32'd0));

    p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd4) |-> !result_we);

endmodule

bind sized_alu_cc sized_alu_cc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .result       (result),
    .result_we    (result_we),
    .ccr_wr_en    (ccr_wr_en),
    .ccr_wr_data  (ccr_wr_data),
    .ccr_logic_en (ccr_logic_en),
    .exc_entry    (exc_entry),
    .ccr_q        (ccr_q),
    .irq_mask     (irq_mask)
);

// File: tb/tb_sized_alu_cc.sv
module tb_sized_alu_cc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        result_we;
    logic        ccr_wr_en = 1'b0;
    logic [7:0]  ccr_wr_data = '0;
    logic        ccr_logic_en = 1'b0;
    logic [1:0]  ccr_logic_fn = '0;
    logic [7:0]  ccr_logic_imm = '0;
    logic        exc_entry = 1'b0;
    logic [7:0]  ccr_q;
    logic        irq_mask;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sized_alu_cc dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .result_we(result_we),
        .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data),
        .ccr_logic_en(ccr_logic_en), .ccr_logic_fn(ccr_logic_fn),
        .ccr_logic_imm(ccr_logic_imm), .exc_entry(exc_entry),
        .ccr_q(ccr_q), .irq_mask(irq_mask)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [31:0] res;
        logic        we;
        logic [4:0]  hnzvc;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 32'h0000000F, 32'h00000001, 1'b0, 32'h00000010, 1'b1, 5'b10000},
        '{3'd0, 2'd0, 32'h0000007F, 32'h00000001, 1'b0, 32'h00000080, 1'b1, 5'b11010},
        '{3'd0, 2'd0, 32'hAB0000FF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 5'b10101},
        '{3'd2, 2'd1, 32'h00001000, 32'h00000001, 1'b0, 32'h00000FFF, 1'b1, 5'b10000},
        '{3'd2, 2'd1, 32'h00008000, 32'h00000001, 1'b0, 32'h00007FFF, 1'b1, 5'b10010},
        '{3'd0, 2'd2, 32'h0FFFFFFF, 32'h00000001, 1'b0, 32'h10000000, 1'b1, 5'b10000},
        '{3'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 5'b10101},
        '{3'd2, 2'd2, 32'h00000000, 32'h00000001, 1'b0, 32'hFFFFFFFF, 1'b1, 5'b11001},
        '{3'd1, 2'd0, 32'h0000000E, 32'h00000001, 1'b1, 32'h00000010, 1'b1, 5'b10000},
        '{3'd3, 2'd0, 32'h00000010, 32'h0000000F, 1'b1, 32'h00000000, 1'b1, 5'b10100},
        '{3'd4, 2'd0, 32'h00000005, 32'h00000007, 1'b0, 32'h000000FE, 1'b0, 5'b11001},
        '{3'd5, 2'd0, 32'h00000080, 32'h00000000, 1'b0, 32'h00000080, 1'b1, 5'b01011},
        '{3'd5, 2'd1, 32'h00000000, 32'h00001234, 1'b0, 32'h00000000, 1'b1, 5'b00100},
        '{3'd0, 2'd1, 32'h0000000F, 32'h00000001, 1'b0, 32'h00000010, 1'b1, 5'b00000},
        '{3'd0, 2'd1, 32'h00000800, 32'h00000800, 1'b0, 32'h00001000, 1'b1, 5'b10000},
        '{3'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 5'b11010},
        '{3'd1, 2'd0, 32'h0000000E, 32'h00000001, 1'b0, 32'h0000000F, 1'b1, 5'b00000},
        '{3'd3, 2'd1, 32'h00000000, 32'h00000000, 1'b1, 32'h0000FFFF, 1'b1, 5'b11001},
        '{3'd0, 2'd1, 32'hFFFF0001, 32'h0000FFFF, 1'b0, 32'h00000000, 1'b1, 5'b10101}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_valid = 1'b0; ccr_wr_en = 1'b0; ccr_logic_en = 1'b0; exc_entry = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_ccr(input logic [7:0] v);
        ccr_wr_en = 1'b1; ccr_wr_data = v;
        step();
        ccr_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1..: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 and R11: reset state
        chk("R1 reset ccr", {24'd0, ccr_q}, 32'h80);
        chk("R11 reset mask", {31'd0, irq_mask}, 32'd1);
        rst = 1'b0;
        step();
        chk("R1 after release", {24'd0, ccr_q}, 32'h80);

        // table walk: R2..R7
        for (int k = 0; k < NV; k++) begin
            load_ccr(8'hD0 | {7'd0, VECS[k].ci});
            op_valid = 1'b1;
            op_code  = VECS[k].op;
            op_size  = VECS[k].sz;
            opnd_a   = VECS[k].a;
            opnd_b   = VECS[k].b;
            #1;
            chk($sformatf("R2 result vec%0d", k), result, VECS[k].res);
            chk($sformatf("R6 write enable vec%0d", k), {31'd0, result_we}, {31'd0, VECS[k].we});
            @(negedge clk);
            op_valid = 1'b0;
            chk($sformatf("R3 R4 R5 R7 flags vec%0d", k), {24'd0, ccr_q},
                {24'd0, 8'hD0 | {2'b00, VECS[k].hnzvc[4], 1'b0, VECS[k].hnzvc[3:0]}});
        end

        // R8 and R11: full load
        load_ccr(8'h00);
        chk("R8 load zero", {24'd0, ccr_q}, 32'h00);
        chk("R11 mask clear", {31'd0, irq_mask}, 32'd0);
        load_ccr(8'hFF);
        chk("R8 load ones", {24'd0, ccr_q}, 32'hFF);

        // R9: merge functions
        ccr_logic_en = 1'b1; ccr_logic_fn = 2'd0; ccr_logic_imm = 8'h5A; step();
        chk("R9 and", {24'd0, ccr_q}, 32'h5A);
        ccr_logic_fn = 2'd1; ccr_logic_imm = 8'h81; step();
        chk("R9 or", {24'd0, ccr_q}, 32'hDB);
        ccr_logic_fn = 2'd2; ccr_logic_imm = 8'hFF; step();
        chk("R9 xor", {24'd0, ccr_q}, 32'h24);
        ccr_logic_fn = 2'd3; ccr_logic_imm = 8'h00; step();
        chk("R9 code3 no change", {24'd0, ccr_q}, 32'h24);
        idle_inputs();

        // R7: idle hold; R2/R6: unused op code does nothing
        step();
        chk("R7 idle hold", {24'd0, ccr_q}, 32'h24);
        op_valid = 1'b1; op_code = 3'd6; op_size = 2'd0; opnd_a = 32'h0; opnd_b = 32'h0;
        #1;
        chk("R6 unused code we", {31'd0, result_we}, 32'd0);
        @(negedge clk);
        chk("R2 unused code no flags", {24'd0, ccr_q}, 32'h24);
        op_valid = 1'b0;
        #1;
        op_code = 3'd0;
        #1;
        chk("R6 not valid we", {31'd0, result_we}, 32'd0);

        // R10: exception entry
        exc_entry = 1'b1; step();
        chk("R10 exc sets I", {24'd0, ccr_q}, 32'hA4);
        chk("R11 mask set", {31'd0, irq_mask}, 32'd1);
        ccr_wr_en = 1'b1; ccr_wr_data = 8'h00; step();
        chk("R10 exc beats write", {24'd0, ccr_q}, 32'h80);
        ccr_wr_en = 1'b0; ccr_logic_en = 1'b1; ccr_logic_fn = 2'd0; ccr_logic_imm = 8'h00; step();
        chk("R10 exc beats and", {24'd0, ccr_q}, 32'h80);
        idle_inputs();

        // R8: write beats merge and operation
        ccr_wr_en = 1'b1; ccr_wr_data = 8'h11;
        ccr_logic_en = 1'b1; ccr_logic_fn = 2'd1; ccr_logic_imm = 8'hFF;
        op_valid = 1'b1; op_code = 3'd0; op_size = 2'd0; opnd_a = 32'h7F; opnd_b = 32'h1;
        step();
        chk("R8 write priority", {24'd0, ccr_q}, 32'h11);
        // R9: merge beats operation
        ccr_wr_en = 1'b0; ccr_logic_fn = 2'd2; ccr_logic_imm = 8'h01;
        step();
        chk("R9 merge priority", {24'd0, ccr_q}, 32'h10);
        idle_inputs();
        step();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule